// File: doc/BRIEF.md
# General-Purpose Port Data Register

This block holds the output data for a 16-pin general-purpose port. It sits on a simple synchronous register bus and has one data word, one bit per pin. For each pin, two control inputs from neighbouring registers choose what a read returns and whether a write reaches the pad. The first is a direction bit, where 1 means output. The second is a mode bit, where 1 means general-purpose and 0 means the pin is handed to another on-chip function.

A write always updates the stored bit. It reaches the pad only for a pin that is a general-purpose output. For that pin the block asserts the output enable and drives the stored value.

On a read, each bit comes from one of three sources:
- the stored bit, when the direction bit is 1;
- the synchronized pin level, for a general-purpose input;
- 0, for an input-direction pin owned by another function.

The stored word is cleared only by the asynchronous power-on reset. The watchdog reset restarts the input synchronizer and leaves the stored word alone. Sleep and standby have no clearing path into the block at all.

Top module: `pdat_port`

## Requirements
- R1: While `por_n` is low, the stored word is all zeros, so a read with every direction bit at 1 returns 0x0000.
- R2: For a pin with direction 1 and mode 1, `pin_oe` is 1 and `pin_out` equals the stored bit. A read of that bit returns the stored bit, whatever level `pin_in` has.
- R3: For a pin with direction 0 and mode 1, a read returns the synchronized pin level. A write still updates the stored bit, which a later read in output direction shows, but the write does not drive the pin.
- R4: For a pin with direction 0 and mode 0, the read bit is 0.
- R5: For a pin with direction 1 and mode 0, a read returns the stored bit, while `pin_oe` and `pin_out` stay 0.
- R6: `bus_be[0]` enables writing bits 7:0 and `bus_be[1]` enables writing bits 15:8. A lane whose enable is 0 keeps its value.
- R7: Asserting `wdt_rst` leaves the stored word, and therefore `pin_out`, unchanged.
- R8: A change on `pin_in` shows up on a read after exactly two rising clock edges, and not after one.
- R9: `pin_oe` is 0 on every pin whose direction or mode bit is 0. On such pins `pin_out` is also 0.
- R10: Pulling `por_n` low clears the stored word at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the data word |
| wdt_rst | input | 1 | Synchronous watchdog reset; clears only the input synchronizer |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_be | input | 2 | Byte-lane write enables (bit 0 = low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from register state |
| dir | input | 16 | Per-pin direction, 1 = output |
| gp_mode | input | 16 | Per-pin mode, 1 = general purpose |
| pin_in | input | 16 | Asynchronous pad input levels |
| pin_out | output | 16 | Pad output data |
| pin_oe | output | 16 | Pad output enables |

## Verification
A corrupted stored bit is visible on the next falling edge, in two places. For a general-purpose output it appears on `pin_out`. On any pin with direction 1 it appears in the read data. A bit that is written to the wrong byte lane, or changed by the watchdog, appears in the same way as soon as the access completes. A fault in the input path (a synchronizer stage skipped, added or reset at the wrong time) changes the read value on the second edge after a pin change, so the bench samples both the first and the second edge after a change.

// File: rtl/pdat_pkg.sv
package pdat_pkg;
    parameter int unsigned PIN_W  = 16;
    parameter int unsigned LANE_W = 8;

    typedef struct packed {
        logic [PIN_W-1:0] data;
    } reg_state_t;
endpackage

// File: rtl/pdat_sync.sv
module pdat_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.s1 = '0;
            st_d.s2 = '0;
        end else begin
            st_d.s1 = d;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pdat_rdmux.sv
module pdat_rdmux #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] stored,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] gp_mode,
    output logic [W-1:0] rd,
    output logic [W-1:0] oe,
    output logic [W-1:0] drv
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (dir[i])          rd[i] = stored[i];
            else if (gp_mode[i]) rd[i] = pin_sync[i];
            else                 rd[i] = 1'b0;
            oe[i]  = dir[i] & gp_mode[i];
            drv[i] = oe[i] ? stored[i] : 1'b0;
        end
    end
endmodule

// File: rtl/pdat_port.sv
module pdat_port #(
    parameter int unsigned W      = pdat_pkg::PIN_W,
    parameter int unsigned LANE_W = pdat_pkg::LANE_W
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     wdt_rst,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [W/LANE_W-1:0]      bus_be,
    input  logic [W-1:0]             bus_wdata,
    output logic [W-1:0]             bus_rdata,
    input  logic [W-1:0]             dir,
    input  logic [W-1:0]             gp_mode,
    input  logic [W-1:0]             pin_in,
    output logic [W-1:0]             pin_out,
    output logic [W-1:0]             pin_oe
);
    localparam int unsigned LANES = W / LANE_W;

    logic [W-1:0] data_d, data_q;
    logic [W-1:0] pin_sync;
    logic [W-1:0] lane_mask;
    logic         wr_hit;

    assign wr_hit = bus_sel & bus_wr;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{bus_be[l]}};
    end

    always_comb begin
        data_d = data_q;
        if (wr_hit)
            data_d = (data_q & ~lane_mask) | (bus_wdata & lane_mask);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) data_q <= '0;
        else        data_q <= data_d;
    end

    pdat_sync #(.W(W)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .clr   (wdt_rst),
        .d     (pin_in),
        .q     (pin_sync)
    );

    pdat_rdmux #(.W(W)) u_rdmux (
        .stored   (data_q),
        .pin_sync (pin_sync),
        .dir      (dir),
        .gp_mode  (gp_mode),
        .rd       (bus_rdata),
        .oe       (pin_oe),
        .drv      (pin_out)
    );
endmodule

// File: rtl/pdat_port_chk.sv
module pdat_port_chk #(
    parameter int unsigned W     = 16,
    parameter int unsigned LANES = 2
) (
    input logic             clk,
    input logic             por_n,
    input logic             wdt_rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [LANES-1:0] bus_be,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     bus_rdata,
    input logic [W-1:0]     dir,
    input logic [W-1:0]     gp_mode,
    input logic [W-1:0]     pin_out,
    input logic [W-1:0]     pin_oe,
    input logic [W-1:0]     data_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !por_n |-> data_q == '0);

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && (&bus_be)) |=> data_q == $past(bus_wdata));

    // R4
    alt_input_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rdata & ~dir & ~gp_mode) == '0);

    // R6
    hi_lane_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && !bus_be[LANES-1]) |=> $stable(data_q[W-1:W-8]));

    // R7
    wdt_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_rst && !(bus_sel && bus_wr)) |=> $stable(data_q));

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((pin_oe & ~(dir & gp_mode)) == '0) && ((pin_out & ~pin_oe) == '0));
endmodule

bind pdat_port pdat_port_chk #(.W(W), .LANES(W/LANE_W)) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .wdt_rst   (wdt_rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dir       (dir),
    .gp_mode   (gp_mode),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .data_q    (data_q)
);

// File: tb/pdat_port_tb.sv
`timescale 1ns/1ps
module pdat_port_tb_top;
    logic        clk = 1'b0;
    logic        por_n, wdt_rst, bus_sel, bus_wr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata, bus_rdata, dir, gp_mode, pin_in, pin_out, pin_oe;

    int unsigned total = 0;
    int unsigned bad   = 0;
    logic [15:0] model = 16'h0;
    bit          done  = 1'b0;

    always #2.5 clk = ~clk;

    pdat_port dut_i (
        .clk(clk), .por_n(por_n), .wdt_rst(wdt_rst), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dir(dir), .gp_mode(gp_mode),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [15:0] exp_rd(logic [15:0] d, logic [15:0] dr,
                                           logic [15:0] gp, logic [15:0] p);
        return (dr & d) | (~dr & gp & p);
    endfunction

    function automatic logic [15:0] exp_oe(logic [15:0] dr, logic [15:0] gp);
        return dr & gp;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] be, logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_be = be; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (be[0]) model[7:0]  = v[7:0];
        if (be[1]) model[15:8] = v[15:8];
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        check({req, " rdata"}, bus_rdata, exp_rd(model, dir, gp_mode, pin_in));
        check({req, " oe"},    pin_oe,    exp_oe(dir, gp_mode));
        check({req, " out"},   pin_out,   model & exp_oe(dir, gp_mode));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        por_n = 1'b0; wdt_rst = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_be = 2'b00; bus_wdata = '0;
        dir = 16'hFFFF; gp_mode = 16'hFFFF; pin_in = 16'h0;
        #12;
        check("R1 reset", bus_rdata, 16'h0000);
        @(negedge clk); por_n = 1'b1;

        // R2 general output: drives pad, reads stored value despite pin
        pin_in = 16'h0F0F;
        wr(2'b11, 16'hA5C3); settle();
        check("R2 rdata", bus_rdata, 16'hA5C3);
        check("R2 out",   pin_out,   16'hA5C3);
        check("R2 oe",    pin_oe,    16'hFFFF);

        // R3 general input: reads pin, write stored only
        @(negedge clk); dir = 16'h0000; pin_in = 16'h3C5A;
        wr(2'b11, 16'h1234); settle();
        check("R3 rdata", bus_rdata, 16'h3C5A);
        check("R3 out",   pin_out,   16'h0000);
        @(negedge clk); dir = 16'hFFFF; gp_mode = 16'h0000; #1;
        // R5 output direction, other function
        check("R3 stored", bus_rdata, 16'h1234);
        check("R5 oe",     pin_oe,    16'h0000);
        check("R5 out",    pin_out,   16'h0000);

        // R4 input direction, other function
        @(negedge clk); dir = 16'h0000; pin_in = 16'hFFFF; settle();
        check("R4 rdata", bus_rdata, 16'h0000);

        // R6 byte lanes
        @(negedge clk); dir = 16'hFFFF; gp_mode = 16'hFFFF;
        wr(2'b01, 16'hFFFF); #1;
        check("R6 low lane", bus_rdata, 16'h12FF);
        wr(2'b10, 16'h0000); #1;
        check("R6 high lane", bus_rdata, 16'h00FF);
        wr(2'b00, 16'hBEEF); #1;
        check("R6 no lane", bus_rdata, 16'h00FF);

        // R8 two-edge latency
        @(negedge clk); dir = 16'h0000; pin_in = 16'h0000; settle(); settle();
        pin_in = 16'hFFFF;
        @(negedge clk);
        check("R8 one edge", bus_rdata, 16'h0000);
        @(negedge clk);
        check("R8 two edges", bus_rdata, 16'hFFFF);

        // R7 watchdog keeps data
        @(negedge clk); dir = 16'hFFFF; wdt_rst = 1'b1;
        @(negedge clk); @(negedge clk); wdt_rst = 1'b0;
        check("R7 rdata", bus_rdata, 16'h00FF);
        check("R7 out",   pin_out,   16'h00FF);

        // R10 asynchronous clear mid-cycle
        @(negedge clk); #1 por_n = 1'b0; #0.5;
        check("R10 async", bus_rdata, 16'h0000);
        check("R10 out",   pin_out,   16'h0000);
        model = 16'h0;
        @(negedge clk); por_n = 1'b1;

        // random mix, R2 R3 R4 R5 R9
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            dir = 16'($urandom); gp_mode = 16'($urandom); pin_in = 16'($urandom);
            if ($urandom % 2) wr(2'($urandom), 16'($urandom));
            settle();
            check_all("R9 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule